// File: doc/BRIEF.md
# Timed Wash Cycle Sequencer

This block steps a washing appliance through one fixed program: a wash period, a drain period and a spin period, and then a return to standby. Time is kept by a single minute counter. A one-cycle tick strobe, synchronous to the system clock, advances it once per minute. The current phase is decoded directly from the range the count falls in. Four registered one-hot indicators show which phase is active.

Counting happens only while the run input is high. Ticks that arrive while run is low are ignored and the count holds. When the last spin minute ends, the block goes back to standby and stays there. It starts again only after a reset, or after run falls and then rises again. An active-low reset at any point clears the count and restarts the program from standby.

With the default durations (10, 2 and 3 minutes) the count runs from 0 to 15:

| Count | Phase |
|---|---|
| 0 | standby |
| 1 to 10 | wash |
| 11 and 12 | drain |
| 13 to 15 | spin |

Top module: `wash_sequencer`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the outputs are {spin,drain,wash,idle} = 4'b0001. Only the standby indicator is on.
- R2: Exactly one of the four indicator outputs is high in every cycle after reset.
- R3: Counting from a fresh start in standby, the first WASH_MIN accepted ticks (ticks 1 to 10 by default) each leave the block in wash.
- R4: The next DRAIN_MIN accepted ticks (ticks 11 and 12 by default) each leave the block in drain.
- R5: The next SPIN_MIN accepted ticks (ticks 13 to 15 by default) each leave the block in spin.
- R6: Phases are visited only in the order standby, wash, drain, spin, standby. No phase is skipped or revisited out of that order.
- R7: While run_en is low, tick strobes are ignored and the indicators hold their values.
- R8: With run_en high, clock cycles that have no tick strobe leave the indicators unchanged.
- R9: The accepted tick after the last spin minute returns the block to standby. Further ticks with run_en held high keep it in standby.
- R10: After the program has completed, a low-then-high transition of run_en re-arms the block, and the next accepted tick enters wash.
- R11: Pulsing reset low in any phase returns the block to standby. The next accepted tick after release enters wash.
- R12: An indicator changes on the same clock edge that samples the tick strobe, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the program |
| min_tick | input | 1 | One-cycle strobe, once per minute, synchronous to clk |
| run_en | input | 1 | Counting is allowed while high; a rising edge re-arms after completion |
| led_idle | output | 1 | Standby indicator |
| led_wash | output | 1 | Wash indicator |
| led_drain | output | 1 | Drain indicator |
| led_spin | output | 1 | Spin indicator |

## Verification
The hardest situation to reach from the ports is the parked standby that follows a completed program. It looks identical to the standby after reset, yet it must ignore ticks until run_en toggles.

The stimulus runs a full 15-tick program and then sends extra ticks with run_en held high, confirming the block stays parked. It then drops run_en for one cycle and raises it again, and confirms that the next tick enters wash.

Reset is also applied from inside each of the three active phases. After each reset, one tick must lead back into wash.

// File: rtl/wash_seq_pkg.sv
package wash_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WASH  = 2'd1,
    PH_DRAIN = 2'd2,
    PH_SPIN  = 2'd3
  } phase_e;

  // Map a minute count onto a phase from the phase lengths.
  function automatic phase_e phase_of(input int cnt, input int wash_len,
                                      input int drain_len);
    if (cnt == 0)                          return PH_IDLE;
    else if (cnt <= wash_len)              return PH_WASH;
    else if (cnt <= wash_len + drain_len)  return PH_DRAIN;
    else                                   return PH_SPIN;
  endfunction

  // One-hot indicator vector, bit index equals phase code.
  function automatic logic [3:0] lamp_of(input phase_e ph);
    return 4'b0001 << ph;
  endfunction

endpackage

// File: rtl/seq_minute_counter.sv
module seq_minute_counter #(
  parameter int TOTAL = 15,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             min_tick,
  input  logic             run_en,
  output logic [CNT_W-1:0] count_nxt,
  output logic [CNT_W-1:0] count_cur
);

  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] ZERO_C = '0;
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             armed_q;
  logic             run_q;

  // Named internal events.
  logic step;    // accepted tick
  logic at_end;  // count sits on last spin minute
  logic wrap;    // program finishes this edge
  logic rise;    // run_en rising edge re-arms
  logic parked;  // completed, waiting for re-arm

  assign step   = min_tick & run_en;
  assign at_end = (count_q == LAST_C);
  assign wrap   = step & at_end;
  assign rise   = run_en & ~run_q;
  assign parked = (count_q == ZERO_C) & ~armed_q;

  always_comb begin
    count_nxt = count_q;
    if (step) begin
      if (at_end)                   count_nxt = ZERO_C;
      else if (count_q != ZERO_C)   count_nxt = count_q + ONE_C;
      else if (armed_q)             count_nxt = ONE_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= ZERO_C;
      armed_q <= 1'b1;
      run_q   <= 1'b0;
    end else begin
      count_q <= count_nxt;
      run_q   <= run_en;
      if (rise)      armed_q <= 1'b1;
      else if (wrap) armed_q <= 1'b0;
    end
  end

  assign count_cur = count_q;

  // R7
  hold_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(count_q));

  // R8
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !min_tick |=> $stable(count_q));

  // R9
  parked_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !rise) |=> (count_q == ZERO_C));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= TOTAL);

endmodule

// File: rtl/seq_phase_lamps.sv
module seq_phase_lamps
  import wash_seq_pkg::*;
#(
  parameter int WASH_MIN  = 10,
  parameter int DRAIN_MIN = 2,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_nxt,
  output logic [3:0]       lamps
);

  phase_e     ph_nxt;
  logic [3:0] lamps_q;

  assign ph_nxt = phase_of(int'(count_nxt), WASH_MIN, DRAIN_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lamps_q <= lamp_of(PH_IDLE);
    else        lamps_q <= lamp_of(ph_nxt);
  end

  assign lamps = lamps_q;

  // R2
  one_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lamps_q) == 1);

  // R6
  wash_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamps_q[PH_WASH]) |-> $past(lamps_q[PH_IDLE]));

  // R6
  drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamps_q[PH_DRAIN]) |-> $past(lamps_q[PH_WASH]));

  // R6
  spin_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamps_q[PH_SPIN]) |-> $past(lamps_q[PH_DRAIN]));

  // R6
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamps_q[PH_IDLE]) |-> $past(lamps_q[PH_SPIN]));

endmodule

// File: rtl/wash_sequencer.sv
module wash_sequencer
  import wash_seq_pkg::*;
#(
  parameter int WASH_MIN  = 10,
  parameter int DRAIN_MIN = 2,
  parameter int SPIN_MIN  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic min_tick,
  input  logic run_en,
  output logic led_idle,
  output logic led_wash,
  output logic led_drain,
  output logic led_spin
);

  localparam int TOTAL = WASH_MIN + DRAIN_MIN + SPIN_MIN;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] count_nxt;
  logic [CNT_W-1:0] count_cur;
  logic [3:0]       lamps;

  seq_minute_counter #(.TOTAL(TOTAL), .CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .min_tick  (min_tick),
    .run_en    (run_en),
    .count_nxt (count_nxt),
    .count_cur (count_cur)
  );

  seq_phase_lamps #(.WASH_MIN(WASH_MIN), .DRAIN_MIN(DRAIN_MIN),
                    .CNT_W(CNT_W)) u_lamps (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_nxt (count_nxt),
    .lamps     (lamps)
  );

  assign led_idle  = lamps[PH_IDLE];
  assign led_wash  = lamps[PH_WASH];
  assign led_drain = lamps[PH_DRAIN];
  assign led_spin  = lamps[PH_SPIN];

  // R12
  lamp_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lamps) |-> $past(min_tick && run_en));

  // R11
  idle_with_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_cur == '0) |-> led_idle);

endmodule

// File: tb/test_wash_sequencer.sv
module test_wash_sequencer;

  localparam int WASH  = 10;
  localparam int DRAIN = 2;
  localparam int SPIN  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic min_tick = 1'b0;
  logic run_en = 1'b0;
  logic led_idle, led_wash, led_drain, led_spin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wash_sequencer #(.WASH_MIN(WASH), .DRAIN_MIN(DRAIN), .SPIN_MIN(SPIN))
    i_wash_sequencer (
      .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .run_en(run_en),
      .led_idle(led_idle), .led_wash(led_wash),
      .led_drain(led_drain), .led_spin(led_spin));

  // Expected indicator vector {spin,drain,wash,idle} after n accepted ticks.
  function automatic logic [3:0] expect_after(input int n);
    if (n < 1)                  return 4'b0001;
    if (n < WASH + 1)           return 4'b0010;
    if (n < WASH + DRAIN + 1)   return 4'b0100;
    if (n < WASH + DRAIN + SPIN + 1) return 4'b1000;
    return 4'b0001;
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {led_spin, led_drain, led_wash, led_idle};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One strobe; outputs update at the posedge inside it, sampled at negedge.
  task automatic pulse_tick();
    @(negedge clk) min_tick = 1'b1;
    @(negedge clk) min_tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(4'b0001, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(4'b0001, "R1 after release");
  endtask

  task automatic t_full_program();
    do_reset();
    run_en = 1'b1;
    for (int n = 1; n <= WASH + DRAIN + SPIN; n++) begin
      pulse_tick();
      if (n <= WASH)              check(expect_after(n), "R3 wash tick");
      else if (n <= WASH + DRAIN) check(expect_after(n), "R4 drain tick");
      else                        check(expect_after(n), "R5 spin tick");
    end
    pulse_tick();
    check(4'b0001, "R9 back to standby");
    for (int k = 0; k < 3; k++) begin
      pulse_tick();
      check(4'b0001, "R9 parked with run high");
    end
  endtask

  task automatic t_rearm();
    @(negedge clk) run_en = 1'b0;
    @(negedge clk) run_en = 1'b1;
    @(negedge clk);
    check(4'b0001, "R10 standby before tick");
    pulse_tick();
    check(4'b0010, "R10 rearmed into wash");
  endtask

  task automatic t_hold();
    do_reset();
    run_en = 1'b1;
    for (int n = 0; n < 4; n++) pulse_tick();
    check(expect_after(4), "R3 wash at tick 4");
    run_en = 1'b0;
    for (int k = 0; k < 8; k++) pulse_tick();
    check(expect_after(4), "R7 held while run low");
    run_en = 1'b1;
    for (int k = 0; k < 10; k++) @(negedge clk);
    check(expect_after(4), "R8 no tick no change");
    for (int n = 5; n <= WASH + 1; n++) pulse_tick();
    check(expect_after(WASH + 1), "R7 resumes into drain");
  endtask

  task automatic t_reset_mid(input int depth, input string tag);
    do_reset();
    run_en = 1'b1;
    for (int n = 0; n < depth; n++) pulse_tick();
    check(expect_after(depth), tag);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    check(4'b0001, "R11 standby after mid reset");
    pulse_tick();
    check(4'b0010, "R11 restart into wash");
  endtask

  // R12: tick edge alignment, output not yet changed before the strobe edge.
  task automatic t_edge_align();
    do_reset();
    run_en = 1'b1;
    @(negedge clk) min_tick = 1'b1;
    #1 check(4'b0001, "R12 before sampling edge");
    @(negedge clk) min_tick = 1'b0;
    check(4'b0010, "R12 after sampling edge");
  endtask

  initial begin
    for (int k = 0; k < 200000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_full_program();
    t_rearm();
    t_hold();
    t_reset_mid(6, "R3 wash before reset");
    t_reset_mid(WASH + 2, "R4 drain before reset");
    t_reset_mid(WASH + DRAIN + 2, "R5 spin before reset");
    t_edge_align();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule